// File: doc/BRIEF.md
# Reference-Loss Detector with Control-Word Holdover

This block watches a horizontal-sync reference that arrives as pulses on a single input. It counts cycles of a local sample clock (27 MHz in the target system) since the last detected rising edge. The loop it serves reports whether it is locked. While it is locked, a gap longer than a programmable limit raises a loss flag. At the same moment, the digital control word that steers the oscillator stops following the loop. It is frozen at the value captured on the last good sync edge.

The limit is not a fixed count. It is the line length in sample clocks plus a guard of three clocks, times the number of tolerated missing lines plus one. The block computes this product and holds it in a register. For a 525-line interlaced format the line length is 1716 clocks, and a setting of 1 gives a limit of 3438 clocks, about 127.3 µs. Holdover ends once two sync edges in a row arrive with no overrun between them. The output then returns to the live loop word.

Top module: `refLossHoldover`

## Requirements
- R1: After reset, lossFlag and holdoverOn are 0, ctrlOut equals loopCtrl, and the captured word is 0.
- R2: With lockedIn high, lossFlag rises when the count of sample clocks since the last detected sync edge becomes strictly greater than L = (lineClocks + 3) × (missThresh + 1). syncIn passes through a two-flop synchronizer and a one-flop edge detector. As a result, lossFlag is still 0 on the (L+4)th rising clock edge after syncIn rises and is 1 from the (L+5)th.
- R3: While lockedIn is low, no gap of any length raises lossFlag.
- R4: While holdoverOn is 1, ctrlOut holds the loopCtrl value sampled on the last sync edge seen while tracking and locked, whatever loopCtrl does. If no edge was captured since reset, that value is 0.
- R5: While holdoverOn is 0, ctrlOut equals loopCtrl in the same cycle.
- R6: Holdover and lossFlag clear together on the second of two consecutive detected sync edges when no overrun of L occurs between them. A single edge, or two edges separated by an overrun, leave holdover set. lossFlag always equals holdoverOn.
- R7: Sync pulses spaced well inside L keep lossFlag at 0, for any lineClocks and missThresh.
- R8: The gap counter saturates above L and does not wrap. If lockedIn rises after an arbitrarily long gap, holdover is entered on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Asynchronous horizontal-sync reference |
| lockedIn | input | 1 | Loop lock indication; arms detection |
| lineClocks | input | LINE_W (12) | Sample clocks per sync period |
| missThresh | input | THR_W (4) | Tolerated missing lines setting |
| loopCtrl | input | CTRL_W (16) | Live loop control word |
| lossFlag | output | 1 | Reference-loss flag |
| holdoverOn | output | 1 | Holdover active |
| ctrlOut | output | CTRL_W (16) | Control word toward the oscillator |

## Verification
The first pattern is the 525-line case with a setting of 1. The bench probes the exact clock edge on which the flag rises, which separates a strict comparison from a non-strict one and exposes any miscounted pipeline stage. The second pattern is a long gap with the loop unlocked, followed by a lock rise. It shows whether detection is gated by lock and whether the counter saturates rather than wraps. The third pattern varies line lengths and thresholds at random, with pulse spacing inside the limit and a control word that changes every cycle. This checks the live path and the absence of false flags. Each random round ends in a loss that verifies the frozen word. Recovery is tried with a single pulse, with two pulses split by an overrun, and with two close pulses, which separates a correct exit rule from one that is too eager.

// File: rtl/rlhPkg.sv
package rlhPkg;
  typedef enum logic [0:0] {ST_TRACK = 1'b0, ST_HOLD = 1'b1} rlhState_t;

  // control -> datapath
  typedef struct packed {
    logic captureEn;
    logic holdSel;
  } rlhStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic syncEdge;
    logic overLimit;
  } rlhStatus_t;
endpackage

// File: rtl/rlhSyncEdge.sv
module rlhSyncEdge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic risePulse
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], asyncIn};
  end

  // pipe[STAGES-1] is the last synchronizer flop, pipe[STAGES] its delayed copy
  assign risePulse = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/rlhDatapath.sv
module rlhDatapath
  import rlhPkg::*;
#(
  parameter int LINE_W = 12,
  parameter int THR_W  = 4,
  parameter int CTRL_W = 16,
  parameter int GUARD  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic [LINE_W-1:0] lineClocks,
  input  logic [THR_W-1:0]  missThresh,
  input  logic [CTRL_W-1:0] loopCtrl,
  input  rlhStrobe_t        strobe,
  output rlhStatus_t        status,
  output logic [CTRL_W-1:0] ctrlOut
);
  // (lineClocks + GUARD) needs LINE_W+1 bits, (missThresh + 1) needs THR_W+1
  localparam int LIM_W = LINE_W + THR_W + 2;

  logic              syncEdge;
  logic [LIM_W-1:0]  lineExt;
  logic [LIM_W-1:0]  mulExt;
  logic [LIM_W-1:0]  limitNext;
  logic [LIM_W-1:0]  limitReg;
  logic [LIM_W-1:0]  gapCnt;
  logic              overLimit;
  logic [CTRL_W-1:0] heldWord;

  rlhSyncEdge #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  (syncIn),
    .risePulse(syncEdge)
  );

  // timeout product, registered to keep the multiplier off the compare path
  assign lineExt   = LIM_W'(lineClocks) + LIM_W'(GUARD);
  assign mulExt    = LIM_W'(missThresh) + LIM_W'(1);
  assign limitNext = lineExt * mulExt;

  always_ff @(posedge clk) begin
    if (!rstN) limitReg <= '0;
    else       limitReg <= limitNext;
  end

  // gap counter: cleared by an edge, saturates one above the limit
  always_ff @(posedge clk) begin
    if (!rstN)                  gapCnt <= '0;
    else if (syncEdge)          gapCnt <= '0;
    else if (gapCnt <= limitReg) gapCnt <= gapCnt + LIM_W'(1);
  end

  assign overLimit = gapCnt > limitReg;

  always_ff @(posedge clk) begin
    if (!rstN)                 heldWord <= '0;
    else if (strobe.captureEn) heldWord <= loopCtrl;
  end

  assign ctrlOut          = strobe.holdSel ? heldWord : loopCtrl;
  assign status.syncEdge  = syncEdge;
  assign status.overLimit = overLimit;
endmodule

// File: rtl/rlhControl.sv
module rlhControl
  import rlhPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lockedIn,
  input  rlhStatus_t status,
  output rlhStrobe_t strobe,
  output logic       lossFlag,
  output logic       holdoverOn
);
  rlhState_t state;
  logic      seenOne;
  logic      flagReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_TRACK;
      seenOne <= 1'b0;
      flagReg <= 1'b0;
    end else begin
      unique case (state)
        ST_TRACK: begin
          if (lockedIn && status.overLimit) begin
            state   <= ST_HOLD;
            flagReg <= 1'b1;
            seenOne <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (status.syncEdge) begin
            if (seenOne) begin
              state   <= ST_TRACK;
              flagReg <= 1'b0;
              seenOne <= 1'b0;
            end else begin
              seenOne <= 1'b1;
            end
          end else if (status.overLimit) begin
            seenOne <= 1'b0;
          end
        end
        default: state <= ST_TRACK;
      endcase
    end
  end

  assign strobe.captureEn = (state == ST_TRACK) && lockedIn && status.syncEdge
                            && !status.overLimit;
  assign strobe.holdSel   = (state == ST_HOLD);
  assign lossFlag         = flagReg;
  assign holdoverOn       = (state == ST_HOLD);
endmodule

// File: rtl/refLossHoldover.sv
module refLossHoldover
  import rlhPkg::*;
#(
  parameter int LINE_W = 12,
  parameter int THR_W  = 4,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic              lockedIn,
  input  logic [LINE_W-1:0] lineClocks,
  input  logic [THR_W-1:0]  missThresh,
  input  logic [CTRL_W-1:0] loopCtrl,
  output logic              lossFlag,
  output logic              holdoverOn,
  output logic [CTRL_W-1:0] ctrlOut
);
  rlhStrobe_t strobe;
  rlhStatus_t status;
  logic       syncEdge;
  logic       overLimit;

  rlhDatapath #(
    .LINE_W(LINE_W), .THR_W(THR_W), .CTRL_W(CTRL_W), .GUARD(3)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .syncIn    (syncIn),
    .lineClocks(lineClocks),
    .missThresh(missThresh),
    .loopCtrl  (loopCtrl),
    .strobe    (strobe),
    .status    (status),
    .ctrlOut   (ctrlOut)
  );

  rlhControl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .lockedIn  (lockedIn),
    .status    (status),
    .strobe    (strobe),
    .lossFlag  (lossFlag),
    .holdoverOn(holdoverOn)
  );

  assign syncEdge  = status.syncEdge;
  assign overLimit = status.overLimit;
endmodule

// File: rtl/rlhChecker.sv
module rlhChecker #(
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              lockedIn,
  input logic [CTRL_W-1:0] loopCtrl,
  input logic [CTRL_W-1:0] ctrlOut,
  input logic              lossFlag,
  input logic              holdoverOn,
  input logic              syncEdge,
  input logic              overLimit
);
  a_r2_flag_after_overrun: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lossFlag) |-> $past(overLimit));

  a_r3_flag_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lossFlag) |-> $past(lockedIn));

  a_r4_hold_steady: assert property (@(posedge clk) disable iff (!rstN)
    (holdoverOn && $past(holdoverOn)) |-> $stable(ctrlOut));

  a_r5_live_path: assert property (@(posedge clk) disable iff (!rstN)
    !holdoverOn |-> (ctrlOut == loopCtrl));

  a_r6_exit_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdoverOn) |-> $past(syncEdge));

  a_r6_flag_matches_hold: assert property (@(posedge clk) disable iff (!rstN)
    lossFlag == holdoverOn);
endmodule

bind refLossHoldover rlhChecker #(.CTRL_W(CTRL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lockedIn  (lockedIn),
  .loopCtrl  (loopCtrl),
  .ctrlOut   (ctrlOut),
  .lossFlag  (lossFlag),
  .holdoverOn(holdoverOn),
  .syncEdge  (syncEdge),
  .overLimit (overLimit)
);

// File: tb/sim_refLossHoldover.sv
`timescale 1ns/1ps
module sim_refLossHoldover;
  localparam int LINE_W = 11;
  localparam int THR_W  = 2;
  localparam int CTRL_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              syncIn = 1'b0;
  logic              lockedIn = 1'b0;
  logic [LINE_W-1:0] lineClocks = '0;
  logic [THR_W-1:0]  missThresh = '0;
  logic [CTRL_W-1:0] loopCtrl = '0;
  logic              lossFlag;
  logic              holdoverOn;
  logic [CTRL_W-1:0] ctrlOut;

  int checks = 0;
  int failures = 0;
  int age = 1000;
  int cycles = 0;
  bit finished = 1'b0;
  logic [CTRL_W-1:0] expHeld = '0;

  refLossHoldover #(.LINE_W(LINE_W), .THR_W(THR_W), .CTRL_W(CTRL_W)) u0 (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .lockedIn(lockedIn),
    .lineClocks(lineClocks), .missThresh(missThresh), .loopCtrl(loopCtrl),
    .lossFlag(lossFlag), .holdoverOn(holdoverOn), .ctrlOut(ctrlOut)
  );

  always #2.5 clk = ~clk;

  function automatic int limOf(input int lc, input int th);
    return (lc + 3) * (th + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one clock: passes one rising edge, then settles 1 ns after the falling edge
  task automatic tick(input bit scramble);
    @(negedge clk);
    cycles++;
    age++;
    if (age == 2) syncIn = 1'b0;
    if (scramble && age >= 5) loopCtrl = CTRL_W'($urandom);
    #1;
  endtask

  task automatic startPulse(input logic [CTRL_W-1:0] v);
    syncIn   = 1'b1;
    loopCtrl = v;
    expHeld  = v;
    age      = 0;
  endtask

  task automatic ticks(input int n, input bit scramble);
    for (int i = 0; i < n; i++) tick(scramble);
  endtask

  // two close pulses end holdover (R6)
  task automatic recover();
    startPulse(CTRL_W'($urandom));
    ticks(40, 1'b1);
    startPulse(CTRL_W'($urandom));
    ticks(4, 1'b0);
    chk(holdoverOn == 1'b0 && lossFlag == 1'b0, "R6 recovery clears", int'(holdoverOn), 0);
    chk(ctrlOut == loopCtrl, "R5 live after recovery", int'(ctrlOut), int'(loopCtrl));
  endtask

  initial begin
    #(5.0 * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    finish();
  end

  initial begin
    int lim;
    void'($urandom(32'h5eed_1983));
    lineClocks = LINE_W'(1716);
    missThresh = THR_W'(1);
    loopCtrl   = 16'hA5C3;
    ticks(4, 1'b0);
    rstN = 1'b1;
    tick(1'b0);
    // R1 reset state
    chk(lossFlag == 1'b0, "R1 flag after reset", int'(lossFlag), 0);
    chk(holdoverOn == 1'b0, "R1 holdover after reset", int'(holdoverOn), 0);
    chk(ctrlOut == loopCtrl, "R1 ctrlOut live after reset", int'(ctrlOut), int'(loopCtrl));

    // R3: long gap with lock low, longer than counter wrap span
    lim = limOf(1716, 1);
    ticks(33000, 1'b0);
    chk(lossFlag == 1'b0, "R3 no flag while unlocked", int'(lossFlag), 0);
    // R8: saturated counter flags on the first locked edge
    lockedIn = 1'b1;
    tick(1'b0);
    chk(lossFlag == 1'b1, "R8 saturated gap flags on lock", int'(lossFlag), 1);
    loopCtrl = 16'h1234;
    #1;
    chk(ctrlOut == 16'h0000, "R4 reset capture held", int'(ctrlOut), 0);

    // R6 negative: single pulse, overrun, single pulse
    startPulse(16'h0BAD);
    ticks(lim + 20, 1'b1);
    chk(holdoverOn == 1'b1, "R6 single pulse keeps hold", int'(holdoverOn), 1);
    startPulse(16'h0BAD);
    ticks(10, 1'b1);
    chk(holdoverOn == 1'b1, "R6 overrun split keeps hold", int'(holdoverOn), 1);
    ticks(30, 1'b1);
    startPulse(16'h0BAD);
    ticks(4, 1'b0);
    chk(holdoverOn == 1'b0, "R6 second close pulse clears", int'(holdoverOn), 0);

    // R2 directed: 525-line case, threshold 1
    ticks(20, 1'b1);
    startPulse(16'h7E81);
    ticks(lim + 4, 1'b1);
    chk(lossFlag == 1'b0, "R2 no flag at L+4", int'(lossFlag), 0);
    tick(1'b1);
    chk(lossFlag == 1'b1, "R2 flag at L+5", int'(lossFlag), 1);
    ticks(3, 1'b1);
    chk(ctrlOut == expHeld, "R4 held word directed", int'(ctrlOut), int'(expHeld));
    recover();

    // random rounds: R7, R5, R2, R4, R6
    for (int r = 0; r < 4; r++) begin
      int lc;
      int th;
      lc = 100 + int'($urandom % 500);
      th = int'($urandom % 4);
      lineClocks = LINE_W'(lc);
      missThresh = THR_W'(th);
      lim = limOf(lc, th);
      tick(1'b0);
      for (int p = 0; p < 6; p++) begin
        int g;
        g = 20 + int'($urandom % 80);
        startPulse(CTRL_W'($urandom));
        for (int c = 0; c < g; c++) begin
          tick(1'b1);
          chk(lossFlag == 1'b0, "R7 no flag with pulses", int'(lossFlag), 0);
          chk(ctrlOut == loopCtrl, "R5 live follow", int'(ctrlOut), int'(loopCtrl));
        end
      end
      startPulse(CTRL_W'($urandom));
      ticks(lim + 4, 1'b1);
      chk(lossFlag == 1'b0, "R2 random no flag at L+4", int'(lossFlag), 0);
      tick(1'b1);
      chk(lossFlag == 1'b1, "R2 random flag at L+5", int'(lossFlag), 1);
      for (int c = 0; c < 8; c++) begin
        tick(1'b1);
        chk(ctrlOut == expHeld, "R4 held word random", int'(ctrlOut), int'(expHeld));
      end
      recover();
    end
    finish();
  end
endmodule